// File: doc/BRIEF.md
# FSK Byte Buffer with Serial Readout

This block sits behind an FSK demodulator running at 1200 baud. It watches the raw demodulated bit stream and finds each asynchronous character, which is a low start bit, eight data bits and a stop bit. A restartable prescaler divides the system clock down to a 16x oversampling tick. A falling edge on the line starts a character. The start bit is confirmed at its centre and then dropped. Each data bit and the stop bit are sampled at their centres.

At the centre of the stop bit, the eight data bits and the sampled stop bit are loaded together into a nine-bit output register. The active-low ready strobe falls in that same step. A controller then clocks the register out on a single serial output, using its own read clock. The first rising edge of that clock also clears the ready strobe. If no edge arrives, the strobe clears itself after half a bit time. Keeping the stop bit lets the reader check framing. A reader that does not care about framing may stop after eight clocks.

A carrier-detect input gates the whole receive path. A sticky overrun flag records that a byte was overwritten before its data bits had been read.

Top module: `fsk_byte_buffer`

## Requirements
- R1: The start bit is never stored; the nine stored bits are the eight data bits followed by the sampled stop bit, and a stop bit sampled as 0 is stored as 0 rather than discarded.
- R2: The load of a completed character happens at the centre of its stop bit (about 9.5 bit times after the start edge, plus the synchroniser delay), and `rdy_n` goes low in the cycle after the load and stays low until a clear condition occurs.
- R3: Each synchronised rising edge of `rd_clk` moves the next stored bit onto `sdo`. Read edge k (k = 1..9) presents stored bit k-1. Bits 0..7 are the data bits in arrival order (the first data bit on the line is bit 0), and bit 8 is the stop bit.
- R4: A read-clock rising edge while `rdy_n` is low returns `rdy_n` high, well before the half-bit timeout.
- R5: Without a read edge, `rdy_n` stays low for exactly OVS/2 × CLK_PER_TICK system clocks (half a bit), then returns high.
- R6: Eight read edges count as a complete read. A following character then does not raise `overrun`, and its own nine bits read out correctly.
- R7: While `carrier_ok` is low, `rdy_n` is held high and line activity neither loads nor alters the stored character. After the carrier returns, the earlier character still reads out unchanged.
- R8: A low pulse on `raw_bit` that has ended before the start-bit centre is rejected and causes no load.
- R9: A load that arrives while fewer than eight bits of the previous character have been read sets `overrun`. The flag stays set until reset, and the new character replaces the old one.
- R10: After reset, `rdy_n` = 1, `sdo` = 1 and `overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_ok | input | 1 | High when a carrier is present; low gates the receiver off |
| raw_bit | input | 1 | Raw demodulated bit, idle high, asynchronous |
| rd_clk | input | 1 | Controller read clock, asynchronous; each rising edge shifts one bit out |
| rdy_n | output | 1 | Active-low byte-ready strobe |
| sdo | output | 1 | Serial data output of the nine-bit register |
| overrun | output | 1 | Sticky flag: a character was overwritten before it was read |

## Verification
The bench builds the block with CLK_PER_TICK = 2, OVS = 16, DATA_BITS = 8 and two synchroniser stages. That makes one bit 32 clocks and the ready timeout 16 clocks. With bits this short, a sweep over all 256 byte values fits in the run. The sweep mixes good and bad stop bits, and it alternates between reading early during the stop bit and letting the timeout expire. The same short timing leaves room for the directed cases: the eight-clock read, the rejected glitch, the carrier gating and the overrun.

// File: rtl/fsk_buf_pkg.sv
package fsk_buf_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;

endpackage

// File: rtl/fsk_sync.sv
module fsk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES < 2) begin : g_bad
         $error("fsk_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/fsk_prescaler.sv
module fsk_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] TOP = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   generate
      if (DIV < 2) begin : g_bad
         $error("fsk_prescaler: DIV must be at least 2");
      end
   endgenerate

   assign tick = (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fsk_char_rx.sv
module fsk_char_rx
   import fsk_buf_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int DATA_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               line,
   input  logic               tick,
   output logic               restart,
   output logic               load,
   output logic [DATA_BITS:0] frame
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
   localparam logic [CNT_W-1:0] MID     = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] LASTBIT = BIT_W'(DATA_BITS - 1);

   rx_state_t              state;
   logic [CNT_W-1:0]       tcnt;
   logic [BIT_W-1:0]       bitn;
   logic [DATA_BITS-1:0]   shreg;
   logic                   line_prev;

   // start candidate: falling edge on the synchronised line while idle
   assign restart = enable && (state == RX_IDLE) && line_prev && !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         tcnt      <= '0;
         bitn      <= '0;
         shreg     <= '0;
         line_prev <= 1'b1;
         load      <= 1'b0;
         frame     <= '1;
      end else begin
         line_prev <= line;
         load      <= 1'b0;
         if (!enable) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: begin
                  if (restart) begin
                     state <= RX_START;
                     tcnt  <= '0;
                  end
               end
               RX_START: begin
                  if (tick) begin
                     if (tcnt == MID) begin
                        tcnt  <= '0;
                        bitn  <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_DATA: begin
                  if (tick) begin
                     if (tcnt == LAST) begin
                        tcnt  <= '0;
                        shreg <= {line, shreg[DATA_BITS-1:1]};
                        if (bitn == LASTBIT) state <= RX_STOP;
                        else                 bitn  <= bitn + 1'b1;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_STOP: begin
                  if (tick) begin
                     if (tcnt == LAST) begin
                        frame <= {line, shreg};
                        load  <= 1'b1;
                        state <= RX_IDLE;
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R7: with carrier gone the receiver returns to idle and produces no load
   assert_rx_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (state == RX_IDLE && !load));

   // R8: a start candidate that reads high at its centre is abandoned
   assert_false_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && state == RX_START && tick && tcnt == MID && line) |=> (state == RX_IDLE && !load));
endmodule

// File: rtl/fsk_read_port.sv
module fsk_read_port #(
   parameter int DATA_BITS = 8,
   parameter int HALF      = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               load,
   input  logic [DATA_BITS:0] frame,
   input  logic               rd_rise,
   output logic               rdy_n,
   output logic               sdo,
   output logic               overrun
);
   localparam int NB     = DATA_BITS + 1;
   localparam int TMR_W  = $clog2(HALF + 1);
   localparam int PEND_W = $clog2(DATA_BITS + 1);

   logic [NB-1:0]     sreg;
   logic [TMR_W-1:0]  tmr;
   logic [PEND_W-1:0] pend;
   logic              ld;

   assign ld = load && enable;

   // register, serial output, unread count and overrun
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '1;
         sdo     <= 1'b1;
         pend    <= '0;
         overrun <= 1'b0;
      end else if (ld) begin
         sreg <= frame;
         pend <= PEND_W'(DATA_BITS);
         if (pend != '0) overrun <= 1'b1;
      end else if (rd_rise) begin
         sdo  <= sreg[0];
         sreg <= {1'b1, sreg[NB-1:1]};
         if (pend != '0) pend <= pend - 1'b1;
      end
   end

   // ready strobe with half-bit timeout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n <= 1'b1;
         tmr   <= '0;
      end else if (!enable) begin
         rdy_n <= 1'b1;
      end else if (ld) begin
         rdy_n <= 1'b0;
         tmr   <= TMR_W'(HALF - 1);
      end else if (!rdy_n) begin
         if (rd_rise || tmr == '0) rdy_n <= 1'b1;
         else                      tmr   <= tmr - 1'b1;
      end
   end

   assert_ready_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> !rdy_n);

   assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !rdy_n && rd_rise && !load) |=> rdy_n);

   assert_timeout_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !rdy_n && !load && tmr == '0) |=> rdy_n);

   assert_no_ready_wo_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> rdy_n);

   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

// File: rtl/fsk_byte_buffer.sv
module fsk_byte_buffer #(
   parameter int CLK_PER_TICK = 2,
   parameter int OVS          = 16,
   parameter int DATA_BITS    = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier_ok,
   input  logic raw_bit,
   input  logic rd_clk,
   output logic rdy_n,
   output logic sdo,
   output logic overrun
);
   localparam int HALF = (OVS / 2) * CLK_PER_TICK;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("fsk_byte_buffer: OVS must be even and at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_db
         $error("fsk_byte_buffer: DATA_BITS must be at least 2");
      end
      if (CLK_PER_TICK < 2) begin : g_bad_cpt
         $error("fsk_byte_buffer: CLK_PER_TICK must be at least 2");
      end
   endgenerate

   logic               line_s, rd_s, rd_prev, rd_rise;
   logic               tick, restart, load;
   logic [DATA_BITS:0] frame;

   fsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bit), .q(line_s));

   fsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .d(rd_clk), .q(rd_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev <= 1'b0;
      else        rd_prev <= rd_s;
   end
   assign rd_rise = rd_s && !rd_prev;

   fsk_prescaler #(.DIV(CLK_PER_TICK)) u_presc (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick));

   fsk_char_rx #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(carrier_ok), .line(line_s), .tick(tick),
      .restart(restart), .load(load), .frame(frame));

   fsk_read_port #(.DATA_BITS(DATA_BITS), .HALF(HALF)) u_port (
      .clk(clk), .rst_n(rst_n), .enable(carrier_ok), .load(load), .frame(frame),
      .rd_rise(rd_rise), .rdy_n(rdy_n), .sdo(sdo), .overrun(overrun));
endmodule

// File: tb/fsk_byte_buffer_test.sv
module fsk_byte_buffer_test;
   localparam int CPT  = 2;
   localparam int OVS  = 16;
   localparam int DB   = 8;
   localparam int BIT  = CPT * OVS;
   localparam int HALF = BIT / 2;
   localparam int WDOG = 190000;

   logic clk = 1'b0, rst_n = 1'b0, carrier_ok = 1'b0, raw_bit = 1'b1, rd_clk = 1'b0;
   logic rdy_n, sdo, overrun;

   int cyc = 0, checks = 0, errors = 0;
   int start_cyc = 0, fall_cyc = 0, low_cnt = 0, low_seen = 0;
   logic mon = 1'b0;
   logic [8:0] got;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (mon && !rdy_n) low_seen <= low_seen + 1;

   fsk_byte_buffer #(.CLK_PER_TICK(CPT), .OVS(OVS), .DATA_BITS(DB), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .raw_bit(raw_bit),
      .rd_clk(rd_clk), .rdy_n(rdy_n), .sdo(sdo), .overrun(overrun));

   always @(negedge clk) begin
      if (cyc >= WDOG) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      @(negedge clk);
      start_cyc = cyc;
      raw_bit = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         raw_bit = b[i];
         repeat (BIT) @(negedge clk);
      end
      raw_bit = stop;
      repeat (BIT) @(negedge clk);
      raw_bit = 1'b1;
   endtask

   task automatic rd_pulse(output logic v);
      rd_clk = 1'b1;
      repeat (4) @(negedge clk);
      rd_clk = 1'b0;
      repeat (4) @(negedge clk);
      v = sdo;
   endtask

   task automatic read_bits(input int first, input int n);
      logic v;
      for (int k = first; k < first + n; k++) begin
         rd_pulse(v);
         got[k] = v;
      end
   endtask

   // wait for the ready strobe and measure its low time (no read)
   task automatic watch_timeout();
      @(negedge rdy_n);
      @(negedge clk);
      fall_cyc = cyc;
      low_cnt = 0;
      while (!rdy_n) begin
         low_cnt++;
         @(negedge clk);
      end
   endtask

   initial begin
      // R10: reset state
      repeat (5) @(negedge clk);
      check(rdy_n === 1'b1, "R10 rdy_n after reset", rdy_n, 1);
      check(sdo === 1'b1, "R10 sdo after reset", sdo, 1);
      check(overrun === 1'b0, "R10 overrun after reset", overrun, 0);
      rst_n = 1'b1;
      carrier_ok = 1'b1;
      repeat (BIT) @(negedge clk);

      // sweep all byte values: mixed stop bits, early read versus timeout
      for (int b = 0; b < 256; b++) begin
         logic stop, early;
         stop  = ((b % 5) != 2);
         early = b[0];
         got   = '0;
         fork
            send_frame(b[7:0], stop);
            begin
               if (early) begin
                  @(negedge rdy_n);
                  @(negedge clk);
                  fall_cyc = cyc;
                  @(negedge clk);
                  check(rdy_n === 1'b0, "R2 ready held low before read", rdy_n, 0);
                  rd_clk = 1'b1;
                  repeat (4) @(negedge clk);
                  check(rdy_n === 1'b1, "R4 first read edge clears ready", rdy_n, 1);
                  rd_clk = 1'b0;
                  repeat (4) @(negedge clk);
                  got[0] = sdo;
               end else begin
                  watch_timeout();
                  check(low_cnt == HALF, "R5 ready low time", low_cnt, HALF);
               end
            end
         join
         check((fall_cyc - start_cyc) >= (BIT * 19) / 2 - 4 &&
               (fall_cyc - start_cyc) <= (BIT * 19) / 2 + 12,
               "R2 load at stop-bit centre", fall_cyc - start_cyc, (BIT * 19) / 2);
         if (early) read_bits(1, 8);
         else       read_bits(0, 9);
         check(got === {stop, b[7:0]}, "R1 R3 stored bits in arrival order", got, {stop, b[7:0]});
         repeat (BIT) @(negedge clk);
      end
      check(overrun === 1'b0, "R6 no overrun after complete reads", overrun, 0);

      // R6: eight reads are a complete read
      fork
         send_frame(8'hA5, 1'b1);
         watch_timeout();
      join
      got = '0;
      read_bits(0, 8);
      check(got[7:0] === 8'hA5, "R6 eight-edge read of data", got[7:0], 8'hA5);
      repeat (BIT) @(negedge clk);
      send_frame(8'h3C, 1'b1);
      repeat (BIT) @(negedge clk);
      check(overrun === 1'b0, "R6 no overrun after eight-edge read", overrun, 0);
      read_bits(0, 9);
      check(got === 9'h13C, "R6 next byte reads out", got, 9'h13C);
      repeat (BIT) @(negedge clk);

      // R8: short glitch rejected
      low_seen = 0;
      mon = 1'b1;
      raw_bit = 1'b0;
      repeat (6) @(negedge clk);
      raw_bit = 1'b1;
      repeat (3 * BIT) @(negedge clk);
      mon = 1'b0;
      check(low_seen == 0, "R8 glitch gives no ready", low_seen, 0);
      send_frame(8'h5A, 1'b0);
      repeat (BIT) @(negedge clk);
      read_bits(0, 9);
      check(got === 9'h05A, "R8 receiver still works after glitch", got, 9'h05A);
      repeat (BIT) @(negedge clk);

      // R7: carrier gating
      send_frame(8'h96, 1'b1);
      repeat (BIT) @(negedge clk);
      carrier_ok = 1'b0;
      repeat (4) @(negedge clk);
      low_seen = 0;
      mon = 1'b1;
      send_frame(8'h69, 1'b1);
      repeat (BIT) @(negedge clk);
      mon = 1'b0;
      check(low_seen == 0, "R7 ready held high without carrier", low_seen, 0);
      carrier_ok = 1'b1;
      repeat (BIT) @(negedge clk);
      read_bits(0, 9);
      check(got === 9'h196, "R7 stored byte unchanged", got, 9'h196);
      check(overrun === 1'b0, "R7 no overrun from gated frame", overrun, 0);
      repeat (BIT) @(negedge clk);

      // R9: overrun and overwrite
      send_frame(8'h11, 1'b1);
      repeat (BIT) @(negedge clk);
      check(overrun === 1'b0, "R9 overrun clear before second load", overrun, 0);
      send_frame(8'hEE, 1'b0);
      repeat (BIT) @(negedge clk);
      check(overrun === 1'b1, "R9 overrun set", overrun, 1);
      read_bits(0, 9);
      check(got === 9'h0EE, "R9 new byte overwrote old", got, 9'h0EE);
      repeat (2 * BIT) @(negedge clk);
      check(overrun === 1'b1, "R9 overrun sticky", overrun, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule